// File: doc/BRIEF.md
# Keyed Firmware Configuration Port

This block gives boot firmware a narrow window onto a table of fixed configuration items. Firmware first writes a 16-bit key into a selector register. It then pulls the chosen item out one byte per access through an 8-bit data register. A byte cursor moves forward on each read, so a sequence of reads walks the item from its first byte to its last. Once the item runs out, or if the key names no item, reads return zero.

The table has two banks of entries, a common bank and a platform bank. Each entry holds a bounded byte buffer and a length. Host-side logic fills the buffers and lengths through a separate load port before firmware runs. Two entries of the common bank come up preset at reset. When firmware selects a key that carries the write flag, it can also fill an entry byte by byte. Writing the last byte produces a single-cycle completion strobe that names the key, and the cursor rewinds to zero.

The register map comes in two variants chosen by a parameter. In the I/O-style layout the data register sits one byte above the selector. In the memory-style layout it sits two bytes above.

Top module: `keyed_cfg_port`

## Requirements
- R1: An access with write set at offset 0 loads `acc_wdata` as the current key and always sets the byte cursor to 0, so the next data read returns byte 0 of the entry.
- R2: Key bit 15 selects the platform bank (1) or the common bank (0). Key bit 14 is the write flag. Key bits 13:0 are the entry index. The same index in the two banks names two independent entries.
- R3: If a selector write carries an index of NUM_ENTRIES (16) or more, the current key becomes 16'hFFFF. While that key is held, data reads return 8'h00 and data writes change nothing.
- R4: A data read on a valid key with cursor below the entry length returns the byte at the cursor and advances the cursor by one. When the cursor equals the length, including an entry of length 0, the read returns 8'h00 and the cursor does not move.
- R5: A data write is stored only when key bit 14 is set, the key is valid and the cursor is below the length. The byte goes to the cursor position and the cursor advances. Any other data write leaves the contents and the cursor unchanged.
- R6: When a stored write brings the cursor to the entry length, `done_pulse` is high for exactly the next cycle with `done_key` equal to the current key, and the cursor returns to 0.
- R7: After reset the current key is 0 and the cursor is 0, so reads return the common-bank entry 0 without any selector write.
- R8: After reset, common entry 0 reads 8'h51, 8'h45, 8'h4D, 8'h55 in that order, length 4. Common entry 1 holds ID_VALUE (default 1) least significant byte first, length 4. Every other entry has length 0.
- R9: The load port writes `ld_data` to byte `ld_addr` of entry (`ld_bank`, `ld_index`) when `ld_byte_we` is high. It sets that entry's length when `ld_len_we` is high. A length above MAX_BYTES (16) is stored as MAX_BYTES.
- R10: The selector is at offset 0. The data register is at offset 1 when MEM_MAPPED=0 and at offset 2 when MEM_MAPPED=1. An access to any other offset reads 8'h00 and changes neither key nor cursor.
- R11: Data-read results appear on `acc_rdata` combinationally in the access cycle. Key and cursor changes take effect at the clock edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | 16 | Key for the selector; low byte for data writes |
| acc_rdata | output | 8 | Data read result |
| ld_byte_we | input | 1 | Load one buffer byte |
| ld_len_we | input | 1 | Load entry length |
| ld_bank | input | 1 | Load target bank |
| ld_index | input | log2(NUM_ENTRIES) | Load target entry |
| ld_addr | input | log2(MAX_BYTES) | Load byte position |
| ld_data | input | 8 | Load byte value |
| ld_len | input | 8 | Load length value, clamped |
| done_pulse | output | 1 | Write-back completion strobe |
| done_key | output | 16 | Key of the completed entry |

## Verification
A data read's byte is due in the same cycle as the access. The bench therefore samples `acc_rdata` one time step after it drives the access and before the closing edge. Cursor and key effects show up only in later accesses, so each one is checked through the value of the next read. The completion strobe is registered, so it is sampled just after the edge that takes the final byte, and again one cycle later to show it has dropped. Host loads are driven for one cycle and take effect at that edge, ahead of any access that follows.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

   localparam int KEY_W    = 16;
   localparam int BANK_BIT = 15;
   localparam int WFLG_BIT = 14;
   localparam int KIDX_W   = 14;
   localparam logic [KEY_W-1:0] BAD_KEY = 16'hFFFF;

   typedef struct packed {
      logic              bank;
      logic              wflag;
      logic [KIDX_W-1:0] idx;
   } key_t;

   // power-on content of one buffer byte
   function automatic logic [7:0] preset_byte(int bank, int ent, int pos,
                                              logic [31:0] id_val);
      logic [7:0] r;
      r = 8'h00;
      if (bank == 0 && ent == 0) begin
         case (pos)
            0: r = 8'h51;
            1: r = 8'h45;
            2: r = 8'h4D;
            3: r = 8'h55;
            default: r = 8'h00;
         endcase
      end else if (bank == 0 && ent == 1 && pos < 4) begin
         r = id_val[pos*8 +: 8];
      end
      return r;
   endfunction

   function automatic int preset_len(int bank, int ent);
      return (bank == 0 && ent < 2) ? 4 : 0;
   endfunction

endpackage

// File: rtl/cfg_key_decode.sv
module cfg_key_decode
   import keyed_cfg_pkg::*;
#(
   parameter int NUM_ENTRIES = 16
) (
   input  logic [KEY_W-1:0]  key_in,
   output logic              bank,
   output logic              wflag,
   output logic [KIDX_W-1:0] idx,
   output logic              in_table
);
   key_t k;

   assign k        = key_t'(key_in);
   assign bank     = k.bank;
   assign wflag    = k.wflag;
   assign idx      = k.idx;
   assign in_table = (k.idx < KIDX_W'(NUM_ENTRIES));

endmodule

// File: rtl/cfg_entry_store.sv
module cfg_entry_store
   import keyed_cfg_pkg::*;
#(
   parameter int          NUM_ENTRIES = 16,
   parameter int          MAX_BYTES   = 16,
   parameter logic [31:0] ID_VALUE    = 32'd1,
   localparam int IDX_W  = $clog2(NUM_ENTRIES),
   localparam int BYTE_W = $clog2(MAX_BYTES),
   localparam int LEN_W  = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   // host load port
   input  logic              ld_byte_we,
   input  logic              ld_len_we,
   input  logic              ld_bank,
   input  logic [IDX_W-1:0]  ld_index,
   input  logic [BYTE_W-1:0] ld_addr,
   input  logic [7:0]        ld_data,
   input  logic [7:0]        ld_len,
   // guest write port
   input  logic              gw_en,
   input  logic              gw_bank,
   input  logic [IDX_W-1:0]  gw_index,
   input  logic [BYTE_W-1:0] gw_addr,
   input  logic [7:0]        gw_data,
   // read port
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_index,
   input  logic [BYTE_W-1:0] rd_addr,
   output logic [7:0]        rd_byte,
   output logic [LEN_W-1:0]  rd_len
);
   localparam int NUM_ENT2 = 2 * NUM_ENTRIES;
   localparam int NCELLS   = NUM_ENT2 * MAX_BYTES;
   localparam int CELL_AW  = 1 + IDX_W + BYTE_W;
   localparam int ENT_AW   = 1 + IDX_W;

   logic [7:0]       cells [NCELLS];
   logic [LEN_W-1:0] lens  [NUM_ENT2];

   logic [LEN_W-1:0] ld_len_clamped;
   logic [CELL_AW-1:0] ld_cell, gw_cell, rd_cell;
   logic [ENT_AW-1:0]  ld_ent, rd_ent;

   assign ld_len_clamped = (ld_len > 8'(MAX_BYTES)) ? LEN_W'(MAX_BYTES)
                                                    : ld_len[LEN_W-1:0];
   assign ld_cell = {ld_bank, ld_index, ld_addr};
   assign gw_cell = {gw_bank, gw_index, gw_addr};
   assign rd_cell = {rd_bank, rd_index, rd_addr};
   assign ld_ent  = {ld_bank, ld_index};
   assign rd_ent  = {rd_bank, rd_index};

   genvar b, e, a;
   generate
      for (b = 0; b < 2; b++) begin : g_bank
         for (e = 0; e < NUM_ENTRIES; e++) begin : g_ent
            localparam int EID = b * NUM_ENTRIES + e;
            logic [LEN_W-1:0] len_q;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  len_q <= LEN_W'(preset_len(b, e));
               else if (ld_len_we && ld_ent == ENT_AW'(EID))
                  len_q <= ld_len_clamped;
            end
            assign lens[EID] = len_q;

            for (a = 0; a < MAX_BYTES; a++) begin : g_byte
               localparam int CID = EID * MAX_BYTES + a;
               logic [7:0] q;

               // host load wins over a guest write to the same byte
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n)
                     q <= preset_byte(b, e, a, ID_VALUE);
                  else if (ld_byte_we && ld_cell == CELL_AW'(CID))
                     q <= ld_data;
                  else if (gw_en && gw_cell == CELL_AW'(CID))
                     q <= gw_data;
               end
               assign cells[CID] = q;
            end
         end
      end
   endgenerate

   assign rd_byte = cells[rd_cell];
   assign rd_len  = lens[rd_ent];

endmodule

// File: rtl/cfg_cursor.sv
module cfg_cursor
   import keyed_cfg_pkg::*;
#(
   parameter int MAX_BYTES = 16,
   localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic [KEY_W-1:0] sel_key,
   input  logic             rd_step,
   input  logic             wr_step,
   input  logic [LEN_W-1:0] ent_len,
   output logic [KEY_W-1:0] key_q,
   output logic [LEN_W-1:0] off_q,
   output logic             done_q,
   output logic [KEY_W-1:0] done_key_q
);
   logic [LEN_W-1:0] off_inc;
   logic             wr_last;

   assign off_inc = off_q + LEN_W'(1);
   assign wr_last = wr_step && (off_inc == ent_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         off_q <= '0;
      end else if (sel_we) begin
         key_q <= sel_key;
         off_q <= '0;
      end else if (wr_last) begin
         off_q <= '0;
      end else if (rd_step || wr_step) begin
         off_q <= off_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q     <= 1'b0;
         done_key_q <= '0;
      end else begin
         done_q <= wr_last;
         if (wr_last)
            done_key_q <= key_q;
      end
   end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import keyed_cfg_pkg::*;
#(
   parameter int          NUM_ENTRIES = 16,
   parameter int          MAX_BYTES   = 16,
   parameter int          ADDR_W      = 2,
   parameter bit          MEM_MAPPED  = 1'b0,
   parameter logic [31:0] ID_VALUE    = 32'd1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           acc_valid,
   input  logic                           acc_write,
   input  logic [ADDR_W-1:0]              acc_addr,
   input  logic [15:0]                    acc_wdata,
   output logic [7:0]                     acc_rdata,
   input  logic                           ld_byte_we,
   input  logic                           ld_len_we,
   input  logic                           ld_bank,
   input  logic [$clog2(NUM_ENTRIES)-1:0] ld_index,
   input  logic [$clog2(MAX_BYTES)-1:0]   ld_addr,
   input  logic [7:0]                     ld_data,
   input  logic [7:0]                     ld_len,
   output logic                           done_pulse,
   output logic [15:0]                    done_key
);
   localparam int IDX_W  = $clog2(NUM_ENTRIES);
   localparam int BYTE_W = $clog2(MAX_BYTES);
   localparam int LEN_W  = $clog2(MAX_BYTES + 1);

   // elaboration-time parameter checks
   generate
      if (NUM_ENTRIES < 2 || (1 << IDX_W) != NUM_ENTRIES) begin : g_bad_ent
         $error("NUM_ENTRIES must be a power of two, at least 2");
      end
      if (MAX_BYTES < 4 || (1 << BYTE_W) != MAX_BYTES) begin : g_bad_bytes
         $error("MAX_BYTES must be a power of two, at least 4");
      end
      if (MAX_BYTES > 255) begin : g_bad_max
         $error("MAX_BYTES must fit the 8-bit length input");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover offsets 0 to 2");
      end
      if (NUM_ENTRIES >= (1 << KIDX_W)) begin : g_bad_key
         $error("NUM_ENTRIES exceeds the key index field");
      end
   endgenerate

   // register map variant
   logic [ADDR_W-1:0] data_ofs;
   generate
      if (MEM_MAPPED) begin : g_mem_map
         assign data_ofs = ADDR_W'(2);
      end else begin : g_io_map
         assign data_ofs = ADDR_W'(1);
      end
   endgenerate

   logic             sel_hit, data_hit;
   logic [KEY_W-1:0] new_key, cur_key;
   logic [LEN_W-1:0] cur_off, cur_len;
   logic             cur_bank, cur_wflag, cur_ok;
   logic [KIDX_W-1:0] cur_idx;
   logic             new_bank, new_wflag, new_ok;
   logic [KIDX_W-1:0] new_idx;
   logic             in_range, rd_step, wr_step;
   logic [7:0]       rd_byte;
   logic [IDX_W-1:0] ent_idx;
   logic [BYTE_W-1:0] ent_pos;

   assign sel_hit  = acc_valid && acc_write && (acc_addr == '0);
   assign data_hit = acc_valid && (acc_addr == data_ofs);

   cfg_key_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_new_dec (
      .key_in   (acc_wdata),
      .bank     (new_bank),
      .wflag    (new_wflag),
      .idx      (new_idx),
      .in_table (new_ok)
   );

   cfg_key_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_cur_dec (
      .key_in   (cur_key),
      .bank     (cur_bank),
      .wflag    (cur_wflag),
      .idx      (cur_idx),
      .in_table (cur_ok)
   );

   assign new_key = new_ok ? {new_bank, new_wflag, new_idx} : BAD_KEY;

   assign ent_idx  = cur_idx[IDX_W-1:0];
   assign ent_pos  = cur_off[BYTE_W-1:0];
   assign in_range = cur_ok && (cur_off < cur_len);
   assign rd_step  = data_hit && !acc_write && in_range;
   assign wr_step  = data_hit && acc_write && cur_wflag && in_range;

   cfg_entry_store #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .MAX_BYTES   (MAX_BYTES),
      .ID_VALUE    (ID_VALUE)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_byte_we (ld_byte_we),
      .ld_len_we  (ld_len_we),
      .ld_bank    (ld_bank),
      .ld_index   (ld_index),
      .ld_addr    (ld_addr),
      .ld_data    (ld_data),
      .ld_len     (ld_len),
      .gw_en      (wr_step),
      .gw_bank    (cur_bank),
      .gw_index   (ent_idx),
      .gw_addr    (ent_pos),
      .gw_data    (acc_wdata[7:0]),
      .rd_bank    (cur_bank),
      .rd_index   (ent_idx),
      .rd_addr    (ent_pos),
      .rd_byte    (rd_byte),
      .rd_len     (cur_len)
   );

   cfg_cursor #(.MAX_BYTES(MAX_BYTES)) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_we     (sel_hit),
      .sel_key    (new_key),
      .rd_step    (rd_step),
      .wr_step    (wr_step),
      .ent_len    (cur_len),
      .key_q      (cur_key),
      .off_q      (cur_off),
      .done_q     (done_pulse),
      .done_key_q (done_key)
   );

   assign acc_rdata = rd_step ? rd_byte : 8'h00;

endmodule

// File: rtl/keyed_cfg_chk.sv
module keyed_cfg_chk #(
   parameter int NUM_ENTRIES = 16,
   parameter int MAX_BYTES   = 16,
   parameter int ADDR_W      = 2,
   parameter bit MEM_MAPPED  = 1'b0,
   localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [15:0]       acc_wdata,
   input logic [7:0]        acc_rdata,
   input logic [15:0]       cur_key,
   input logic [LEN_W-1:0]  cur_off,
   input logic              done_pulse
);
   localparam logic [ADDR_W-1:0] DOFS = MEM_MAPPED ? ADDR_W'(2) : ADDR_W'(1);

   logic sel_wr, dat_rd, dat_wr;
   assign sel_wr = acc_valid && acc_write && (acc_addr == '0);
   assign dat_rd = acc_valid && !acc_write && (acc_addr == DOFS);
   assign dat_wr = acc_valid && acc_write && (acc_addr == DOFS);

   AST_SEL_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (cur_off == '0)); // R1

   AST_BAD_KEY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && acc_wdata[13:0] >= 14'(NUM_ENTRIES)) |=> (cur_key == 16'hFFFF)); // R3

   AST_BAD_KEY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && cur_key == 16'hFFFF) |-> (acc_rdata == 8'h00)); // R3

   AST_OFS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cur_off <= LEN_W'(MAX_BYTES)); // R4

   AST_RO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !cur_key[14]) |=> $stable(cur_off)); // R5

   AST_DONE_REWOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (cur_off == '0)); // R6

   AST_OTHER_OFS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr != DOFS) |-> (acc_rdata == 8'h00)); // R10

endmodule

bind keyed_cfg_port keyed_cfg_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .MAX_BYTES   (MAX_BYTES),
   .ADDR_W      (ADDR_W),
   .MEM_MAPPED  (MEM_MAPPED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .acc_addr   (acc_addr),
   .acc_wdata  (acc_wdata),
   .acc_rdata  (acc_rdata),
   .cur_key    (cur_key),
   .cur_off    (cur_off),
   .done_pulse (done_pulse)
);

// File: tb/tb_keyed_cfg_port.sv
`timescale 1ns/1ps
module tb_keyed_cfg_port;
   localparam int NE = 16;
   localparam int MB = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [1:0]  acc_addr = '0;
   logic [15:0] acc_wdata = '0;
   logic [7:0]  acc_rdata;
   logic        ld_byte_we = 1'b0, ld_len_we = 1'b0, ld_bank = 1'b0;
   logic [3:0]  ld_index = '0, ld_addr = '0;
   logic [7:0]  ld_data = '0, ld_len = '0;
   logic        done_pulse;
   logic [15:0] done_key;

   int total = 0;
   int bad   = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   keyed_cfg_port dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .ld_byte_we(ld_byte_we), .ld_len_we(ld_len_we), .ld_bank(ld_bank),
      .ld_index(ld_index), .ld_addr(ld_addr), .ld_data(ld_data),
      .ld_len(ld_len), .done_pulse(done_pulse), .done_key(done_key)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] a, input logic w, input logic [15:0] d,
                      output logic [7:0] r);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
      #1 r = acc_rdata;
      @(posedge clk);
      #1 acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic sel(input logic [15:0] k);
      logic [7:0] r;
      acc(2'd0, 1'b1, k, r);
   endtask

   task automatic rd(output logic [7:0] r);
      acc(2'd1, 1'b0, 16'h0, r);
   endtask

   task automatic wr(input logic [7:0] d);
      logic [7:0] r;
      acc(2'd1, 1'b1, {8'h00, d}, r);
   endtask

   task automatic host_byte(input int b, input int i, input int a, input logic [7:0] d);
      @(negedge clk);
      ld_byte_we = 1'b1; ld_bank = b[0]; ld_index = i[3:0]; ld_addr = a[3:0]; ld_data = d;
      @(posedge clk);
      #1 ld_byte_we = 1'b0;
   endtask

   task automatic host_len(input int b, input int i, input logic [7:0] l);
      @(negedge clk);
      ld_len_we = 1'b1; ld_bank = b[0]; ld_index = i[3:0]; ld_len = l;
      @(posedge clk);
      #1 ld_len_we = 1'b0;
   endtask

   function automatic logic [7:0] pat(int b, int i, int a);
      return 8'((b * 8'h80) ^ (i * 8'h11) ^ (a * 8'h07) ^ 8'h3C);
   endfunction

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] sig [4];
      sig[0] = 8'h51; sig[1] = 8'h45; sig[2] = 8'h4D; sig[3] = 8'h55;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R7 R8: reset selection is common entry 0
      check(done_pulse == 1'b0, "R7 no strobe after reset", done_pulse, 0);
      for (int a = 0; a < 6; a++) begin
         rd(rv);
         check(rv == ((a < 4) ? sig[a] : 8'h00), "R8 signature", rv, (a < 4) ? sig[a] : 0);
      end
      // R8: identifier entry, LSB first
      sel(16'h0001);
      for (int a = 0; a < 5; a++) begin
         rd(rv);
         check(rv == ((a == 0) ? 8'h01 : 8'h00), "R8 id value", rv, (a == 0) ? 1 : 0);
      end
      // R8: other entries empty
      sel(16'h0002); rd(rv); check(rv == 8'h00, "R8 empty common entry", rv, 0);
      sel(16'h8000); rd(rv); check(rv == 8'h00, "R8 empty platform entry", rv, 0);
      // R1: reselect rewinds
      sel(16'h0000); rd(rv); rd(rv);
      sel(16'h0000); rd(rv); check(rv == 8'h51, "R1 reselect rewinds", rv, 8'h51);

      // R9 R2 R4: sweep every entry of both banks, lengths 0..17
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < NE; i++) begin
            for (int a = 0; a < MB; a++) host_byte(b, i, a, pat(b, i, a));
            host_len(b, i, 8'((i + 5 * b) % 18));
         end
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < NE; i++) begin
            int el;
            el = (i + 5 * b) % 18;
            if (el > MB) el = MB;
            sel(16'((b << 15) | i));
            for (int a = 0; a < MB + 2; a++) begin
               logic [7:0] ex;
               ex = (a < el) ? pat(b, i, a) : 8'h00;
               rd(rv);
               check(rv == ex, "R4 R9 R2 sweep read", rv, ex);
            end
         end
      // R9: large length clamps
      host_len(0, 3, 8'hFF);
      sel(16'h0003);
      for (int a = 0; a < MB + 1; a++) begin
         rd(rv);
         check(rv == ((a < MB) ? pat(0, 3, a) : 8'h00), "R9 clamp 255", rv,
               (a < MB) ? pat(0, 3, a) : 0);
      end

      // R3: out-of-table keys
      sel(16'h0010); rd(rv); check(rv == 8'h00, "R3 index 16 reads zero", rv, 0);
      rd(rv); check(rv == 8'h00, "R3 still zero", rv, 0);
      sel(16'h7FFF); wr(8'hAB);
      check(done_pulse == 1'b0, "R3 write on bad key", done_pulse, 0);
      rd(rv); check(rv == 8'h00, "R3 bad key read", rv, 0);

      // R5 R6: write-back to platform entry 5, length 3
      host_len(1, 5, 8'd3);
      sel(16'hC005);
      wr(8'h11); check(done_pulse == 1'b0, "R6 no early strobe", done_pulse, 0);
      wr(8'h22); check(done_pulse == 1'b0, "R6 no early strobe", done_pulse, 0);
      wr(8'h33);
      check(done_pulse == 1'b1, "R6 strobe on last byte", done_pulse, 1);
      check(done_key == 16'hC005, "R6 strobe key", done_key, 16'hC005);
      @(posedge clk); #1;
      check(done_pulse == 1'b0, "R6 strobe one cycle", done_pulse, 0);
      rd(rv); check(rv == 8'h11, "R6 cursor rewound", rv, 8'h11);
      sel(16'h8005);
      rd(rv); check(rv == 8'h11, "R5 stored byte 0", rv, 8'h11);
      rd(rv); check(rv == 8'h22, "R5 stored byte 1", rv, 8'h22);
      rd(rv); check(rv == 8'h33, "R5 stored byte 2", rv, 8'h33);
      rd(rv); check(rv == 8'h00, "R4 past end", rv, 0);
      // R5: write without flag ignored
      sel(16'h8005); wr(8'h99);
      check(done_pulse == 1'b0, "R5 read-only write no strobe", done_pulse, 0);
      rd(rv); check(rv == 8'h11, "R5 read-only write ignored", rv, 8'h11);
      // R2: common bank same index untouched
      sel(16'h0005); rd(rv); check(rv == pat(0, 5, 0), "R2 other bank intact", rv, pat(0, 5, 0));
      // R5: write to empty entry ignored
      host_len(0, 7, 8'd0);
      sel(16'h4007); wr(8'h55);
      check(done_pulse == 1'b0, "R5 empty entry write", done_pulse, 0);

      // R10: other offsets
      sel(16'hC005);
      acc(2'd2, 1'b0, 16'h0, rv); check(rv == 8'h00, "R10 offset 2 reads zero", rv, 0);
      acc(2'd3, 1'b0, 16'h0, rv); check(rv == 8'h00, "R10 offset 3 reads zero", rv, 0);
      acc(2'd2, 1'b1, 16'h0077, rv);
      acc(2'd0, 1'b0, 16'h0, rv); check(rv == 8'h00, "R10 selector reads zero", rv, 0);
      rd(rv); check(rv == 8'h11, "R10 R11 offset 2 write ignored", rv, 8'h11);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule